// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block merges eight interrupt request lines into one interrupt output for a processor. Each line has a bit in three registers: a request register that catches rising edges, a mask register, and an in-service register that records which levels the processor is handling. Input 0 has the highest priority and input 7 the lowest. The interrupt output is raised only when an unmasked request outranks every level that is already in service. A nested handler can therefore be interrupted only by a more urgent source.

Software reaches the block through a port with two addresses. The command address (`addr`=0) takes a start-of-setup word, end-of-interrupt commands and readback selection. The data address (`addr`=1) takes the setup words and, at all other times, the mask. The setup sequence gives the vector base, the cascade wiring, which is shown on `cas_cfg` for the logic that links chained controllers, and an optional mode word that turns on automatic end-of-interrupt.

When the processor acknowledges with a one-cycle `ack` pulse, the block answers with an 8-bit vector. The vector is the base plus the winning input. If no request qualifies at that moment, the vector is the base plus 7 and no in-service bit changes.

The vector output works like a stream source without back-pressure. `vec_vld` is high for exactly one cycle for every `ack`, and the consumer must take `vec_out` in that cycle. There is no ready signal, because each vector answers a single request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low and setup is not complete (`cfg_done`=0). Data-port reads return mask 0xFF. Command-port reads return the request register, which is 0x00. `vec_vld` is low.
- R2: A command-port write with bit 4 set starts setup and clears the in-service register. The next data-port writes are taken as the vector base, then the cascade word, then the mode word. The mode word is expected only if bit 0 of the start word was 1. `cfg_done` rises after the last expected word, and `cas_cfg` shows the cascade word.
- R3: For every `ack` pulse, `vec_vld` is high in the following cycle, with `vec_out` equal to the vector base plus the acknowledged input number.
- R4: A rising edge on `irq_in[n]` sets request bit n. Acknowledging level n clears that bit. A line that is held high does not set the bit again.
- R5: A data-port write outside the setup sequence loads the mask, and data-port reads return it. A request on a masked input stays in the request register but does not raise `int_out`.
- R6: Priority is fixed, with input 0 the highest. `int_out` is high only when the lowest-numbered unmasked request is lower-numbered than every in-service bit.
- R7: A command-port write of 0x60 plus a level L (0 to 7) clears in-service bit L and no other bit.
- R8: If bit 1 of the mode word is 1 (automatic end-of-interrupt), an acknowledge sets no in-service bit. A start word with bit 0 clear turns this mode off.
- R9: A command write of 0x0A selects the request register for command-port reads, and 0x0B selects the in-service register. The selection lasts until the next such write or the next start word, which selects the request register.
- R10: An acknowledge when no request qualifies returns the base plus 7, leaves the in-service register unchanged, and leaves any masked request pending.
- R11: `int_out` stays low while setup is not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, edge-sensitive |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from `addr` |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Vector for the acknowledge |
| vec_vld | output | 1 | `vec_out` is valid this cycle |
| cas_cfg | output | 8 | Cascade word from setup |
| cfg_done | output | 1 | Setup sequence complete |

## Verification
Each result is due a fixed number of cycles after its stimulus:

| Result | When it is due |
|---|---|
| Request register bit | At the clock edge that samples the rising input |
| Register write effect | At the edge that takes the write |
| `int_out` | From state only, so it changes with the registers it depends on |
| Vector | One edge after the `ack` edge |
| `rd_data` | Combinational, so it follows `addr` at once |

The bench drives inputs at the falling edge and holds each one for one full cycle. It checks `rd_data`, `int_out` and `cfg_done` at the next falling edge. The acknowledge task pushes the expected vector into a queue. A monitor pops that queue at each falling edge where `vec_vld` is high, so every vector is compared exactly one cycle after its `ack`. At the end, a non-empty queue counts as a failure.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BASE = 3'd1,
    ST_CAS  = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } cfg_st_e;

  localparam int START_BIT   = 4;
  localparam int NEED4_BIT   = 0;
  localparam int AUTO_BIT    = 1;
  localparam logic [4:0] EOI_TAG = 5'b01100;
  localparam logic [7:0] SEL_REQ = 8'h0A;
  localparam logic [7:0] SEL_SRV = 8'h0B;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int NUM_IN = 8,
  localparam int LVL_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              clr_vld,
  input  logic [LVL_W-1:0]  clr_idx,
  output logic [NUM_IN-1:0] irr
);
  logic [NUM_IN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_bit
    logic edge_w;
    assign edge_w = irq_in[g] & ~prev_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n)                                        irr[g] <= 1'b0;
      else if (edge_w)                                   irr[g] <= 1'b1;
      else if (clr_vld && clr_idx == LVL_W'(g))          irr[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int NUM_IN = 8,
  localparam int LVL_W = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0] irr,
  input  logic [NUM_IN-1:0] imr,
  input  logic [NUM_IN-1:0] isr,
  output logic              win_vld,
  output logic [LVL_W-1:0]  win_idx
);
  logic [NUM_IN-1:0] pend;
  logic              req_hit, srv_hit;
  logic [LVL_W-1:0]  srv_idx;

  assign pend = irr & ~imr;

  always_comb begin
    req_hit = 1'b0;
    win_idx = '0;
    srv_hit = 1'b0;
    srv_idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend[i]) begin
        req_hit = 1'b1;
        win_idx = LVL_W'(i);
      end
      if (isr[i]) begin
        srv_hit = 1'b1;
        srv_idx = LVL_W'(i);
      end
    end
    win_vld = req_hit && (!srv_hit || (win_idx < srv_idx));
  end
endmodule

// File: rtl/pic_cfg_port.sv
module pic_cfg_port
  import prio_irq_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int VEC_W  = 8,
  localparam int LVL_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [7:0]        wr_data,
  output logic [VEC_W-1:0]  base,
  output logic [7:0]        cas,
  output logic              aeoi,
  output logic [NUM_IN-1:0] imr,
  output logic              sel_srv,
  output logic              cfg_done,
  output logic              init_pls,
  output logic              eoi_vld,
  output logic [LVL_W-1:0]  eoi_lvl
);
  cfg_st_e st_q;
  logic    need4_q;
  logic    cmd_wr, dat_wr;

  assign cmd_wr   = wr_en && !addr;
  assign dat_wr   = wr_en && addr;
  assign cfg_done = (st_q == ST_RUN);
  assign init_pls = cmd_wr && wr_data[START_BIT];
  assign eoi_vld  = cmd_wr && !wr_data[START_BIT] && cfg_done && (wr_data[7:3] == EOI_TAG);
  assign eoi_lvl  = wr_data[LVL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      need4_q <= 1'b0;
      base    <= '0;
      cas     <= '0;
      aeoi    <= 1'b0;
      imr     <= '1;
      sel_srv <= 1'b0;
    end else if (init_pls) begin
      st_q    <= ST_BASE;
      need4_q <= wr_data[NEED4_BIT];
      aeoi    <= 1'b0;
      sel_srv <= 1'b0;
    end else if (cmd_wr && cfg_done) begin
      if (wr_data == SEL_REQ)      sel_srv <= 1'b0;
      else if (wr_data == SEL_SRV) sel_srv <= 1'b1;
    end else if (dat_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base <= VEC_W'(wr_data);
          st_q <= ST_CAS;
        end
        ST_CAS: begin
          cas  <= wr_data;
          st_q <= need4_q ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          aeoi <= wr_data[AUTO_BIT];
          st_q <= ST_RUN;
        end
        default: imr <= wr_data[NUM_IN-1:0];
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IN = 8,
  parameter int VEC_W  = 8,
  localparam int LVL_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              int_out,
  input  logic              ack,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_vld,
  output logic [7:0]        cas_cfg,
  output logic              cfg_done
);
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NUM_IN - 1);

  logic [VEC_W-1:0]  base_w;
  logic              aeoi_w, sel_srv_w, init_pls_w, eoi_vld_w;
  logic [LVL_W-1:0]  eoi_lvl_w, win_idx_w;
  logic [NUM_IN-1:0] imr_w, irr_w, isr_q, isr_d;
  logic              win_vld_w, ack_take;

  pic_cfg_port #(.NUM_IN(NUM_IN), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .base(base_w), .cas(cas_cfg), .aeoi(aeoi_w), .imr(imr_w), .sel_srv(sel_srv_w),
    .cfg_done(cfg_done), .init_pls(init_pls_w), .eoi_vld(eoi_vld_w), .eoi_lvl(eoi_lvl_w)
  );

  pic_req_latch #(.NUM_IN(NUM_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .clr_vld(ack_take), .clr_idx(win_idx_w), .irr(irr_w)
  );

  pic_prio_resolve #(.NUM_IN(NUM_IN)) u_prio (
    .irr(irr_w), .imr(imr_w), .isr(isr_q),
    .win_vld(win_vld_w), .win_idx(win_idx_w)
  );

  assign int_out  = cfg_done && win_vld_w;
  assign ack_take = ack && int_out;

  always_comb begin
    isr_d = isr_q;
    if (eoi_vld_w)           isr_d[eoi_lvl_w] = 1'b0;
    if (ack_take && !aeoi_w) isr_d[win_idx_w] = 1'b1;
    if (init_pls_w)          isr_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q   <= '0;
      vec_out <= '0;
      vec_vld <= 1'b0;
    end else begin
      isr_q   <= isr_d;
      vec_vld <= ack;
      if (ack) vec_out <= base_w + VEC_W'(ack_take ? win_idx_w : SPUR_LVL);
    end
  end

  assign rd_data = addr ? 8'(imr_w) : (sel_srv_w ? 8'(isr_q) : 8'(irr_w));
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_IN = 8,
  localparam int LVL_W = $clog2(NUM_IN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              vec_vld,
  input logic              int_out,
  input logic              cfg_done,
  input logic              wr_en,
  input logic              addr,
  input logic [7:0]        wr_data,
  input logic [NUM_IN-1:0] imr,
  input logic [NUM_IN-1:0] irr,
  input logic [NUM_IN-1:0] isr,
  input logic              aeoi
);
  a_r3_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_vld);
  a_r3_no_stray_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_vld);
  a_r11_quiet_uninit: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !int_out);
  a_r5_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_out);
  a_r6_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && wr_en && !addr && wr_data[7:3] == 5'b01100 && !ack)
      |=> !isr[$past(wr_data[LVL_W-1:0])]);
  a_r8_auto_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && cfg_done && ack && !(wr_en && !addr)) |=> $stable(isr));
  a_r10_spur_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !(wr_en && !addr)) |=> $stable(isr));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .vec_vld(vec_vld), .int_out(int_out),
  .cfg_done(cfg_done), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .imr(imr_w), .irr(irr_w), .isr(isr_q), .aeoi(aeoi_w)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       int_out;
  logic       ack = 1'b0;
  logic [7:0] vec_out;
  logic       vec_vld;
  logic [7:0] cas_cfg;
  logic       cfg_done;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .int_out(int_out), .ack(ack),
    .vec_out(vec_out), .vec_vld(vec_vld), .cas_cfg(cas_cfg), .cfg_done(cfg_done)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Monitor: compares each vector in the cycle after its acknowledge
  always @(negedge clk) begin
    if (rst_n && vec_vld) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected vector", vec_out, 8'hxx);
      end else begin
        chk("R3 vector", vec_out, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic drive_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] exp);
    @(negedge clk);
    exp_q.push_back(exp);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 cfg_done", {7'd0, cfg_done}, 8'h00);
    chk("R1 vec_vld", {7'd0, vec_vld}, 8'h00);
    rd("R1 mask", 1'b1, 8'hFF);
    rd("R1 request readback", 1'b0, 8'h00);

    // R11 no interrupt before setup, R4/R5 edge latches while uninitialized
    wr(1'b1, 8'h00);
    drive_irq(8'h08);
    chk("R11 int_out uninit", {7'd0, int_out}, 8'h00);
    rd("R4 edge sets request", 1'b0, 8'h08);

    // R2 four-word setup
    wr(1'b0, 8'h11);
    chk("R2 busy after start", {7'd0, cfg_done}, 8'h00);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    chk("R2 busy before mode word", {7'd0, cfg_done}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R2 done", {7'd0, cfg_done}, 8'h01);
    chk("R2 cascade word", cas_cfg, 8'h04);
    chk("R6 int_out pending 3", {7'd0, int_out}, 8'h01);
    do_ack(8'h23);
    wr(1'b0, 8'h0B);
    rd("R9 in-service readback", 1'b0, 8'h08);
    wr(1'b0, 8'h0A);
    rd("R4 ack clears, held line no retrigger", 1'b0, 8'h00);

    // R6 nesting with R7 specific EOI
    drive_irq(8'h28);
    chk("R6 lower level blocked", {7'd0, int_out}, 8'h00);
    drive_irq(8'h2A);
    chk("R6 higher level passes", {7'd0, int_out}, 8'h01);
    do_ack(8'h21);
    chk("R6 nested both in service", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h61);
    wr(1'b0, 8'h0B);
    rd("R7 eoi clears only level 1", 1'b0, 8'h08);
    chk("R6 level 5 still below 3", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h63);
    chk("R6 level 5 now passes", {7'd0, int_out}, 8'h01);
    do_ack(8'h25);
    rd("R9 selection persists", 1'b0, 8'h20);
    wr(1'b0, 8'h65);
    rd("R7 eoi level 5", 1'b0, 8'h00);
    drive_irq(8'h00);

    // R5 masking
    wr(1'b1, 8'h04);
    drive_irq(8'h04);
    chk("R5 masked quiet", {7'd0, int_out}, 8'h00);
    rd("R5 mask readback", 1'b1, 8'h04);
    wr(1'b0, 8'h0A);
    rd("R5 masked request kept", 1'b0, 8'h04);
    wr(1'b1, 8'h00);
    chk("R5 unmask raises", {7'd0, int_out}, 8'h01);
    do_ack(8'h22);
    wr(1'b0, 8'h62);
    drive_irq(8'h00);

    // R10 spurious acknowledge
    drive_irq(8'h40);
    chk("R10 pending 6", {7'd0, int_out}, 8'h01);
    wr(1'b1, 8'hFF);
    chk("R10 request gone", {7'd0, int_out}, 8'h00);
    do_ack(8'h27);
    wr(1'b0, 8'h0B);
    rd("R10 no in-service set", 1'b0, 8'h00);
    wr(1'b0, 8'h0A);
    rd("R10 masked request still pending", 1'b0, 8'h40);
    wr(1'b1, 8'h00);
    do_ack(8'h26);
    wr(1'b0, 8'h66);
    do_ack(8'h27);
    rd("R4 held line no retrigger", 1'b0, 8'h00);
    drive_irq(8'h00);

    // R2 three-word setup, then mask load
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h80);
    wr(1'b1, 8'h04);
    chk("R2 three-word done", {7'd0, cfg_done}, 8'h01);
    wr(1'b1, 8'h0F);
    rd("R5 mask after setup", 1'b1, 8'h0F);
    drive_irq(8'h10);
    do_ack(8'h84);
    wr(1'b0, 8'h0B);
    rd("R8 normal mode sets in-service", 1'b0, 8'h10);
    wr(1'b0, 8'h64);
    drive_irq(8'h00);

    // R8 automatic end-of-interrupt
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h03);
    chk("R2 cascade id", cas_cfg, 8'h02);
    rd("R9 start word reselects request", 1'b0, 8'h00);
    drive_irq(8'h30);
    do_ack(8'h44);
    wr(1'b0, 8'h0B);
    rd("R8 no in-service after ack", 1'b0, 8'h00);
    chk("R8 next request not blocked", {7'd0, int_out}, 8'h01);
    do_ack(8'h45);
    chk("R8 idle", {7'd0, int_out}, 8'h00);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R3 missing vectors", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule